// File: doc/BRIEF.md
# Contact Input Debounce and Edge Pulser

This block conditions one asynchronous mechanical contact for synchronous logic. The raw level first crosses into the clock domain through a chain of flip-flops. A periodic sample strobe then feeds the synchronized bit into a run-length filter. The filter accepts a new level only once the input has held that value for `RUN_LEN` samples in a row. The filtered level is then turned into a rise pulse and a fall pulse. Each pulse can be widened so that a consumer on a slower clock still sees it.

Two filter variants are chosen by parameter. One keeps a window of the last `RUN_LEN` samples and switches when the whole window agrees. The other uses a saturating up/down count. That count sets the level at the top of its range, clears it at the bottom, and holds it everywhere in between. All pins are plain control signals. The block has no data stream and no handshake.

Top module: `contact_debounce`

## Requirements
- R1: A change on `raw_i` reaches the filter after exactly `SYNC_STAGES` clock edges (2 or 3). From a settled low with `tick_i` held high, `level_o` rises after `SYNC_STAGES + RUN_LEN` edges following the first edge that sees `raw_i` high.
- R2: The filter state and `level_o` change only at edges where `tick_i` is 1. With `tick_i` at 0, `level_o` holds whatever `raw_i` does.
- R3: In window mode (`FILTER_MODE = FLT_SHIFT`), `level_o` becomes 1 after `RUN_LEN` consecutive sampled ones. It becomes 0 after `RUN_LEN` consecutive sampled zeros. Otherwise it holds.
- R4: In count mode (`FILTER_MODE = FLT_COUNT`), each sampled 1 increments the count and each sampled 0 decrements it, clamped to 0..`RUN_LEN`. `level_o` becomes 1 when the count reaches `RUN_LEN`, becomes 0 when it reaches 0, and holds otherwise.
- R5: Reset (`rst_ni` low, asynchronous) clears the synchronizer, the filter state and `level_o`. No rise or fall pulse appears after reset until the level has changed.
- R6: When `level_o` goes 0→1, `rise_o` goes high on the next edge and stays high for `PULSE_W` cycles.
- R7: When `level_o` goes 1→0, `fall_o` goes high on the next edge and stays high for `PULSE_W` cycles.
- R8: `PULSE_W = max(1, ceil(DST_PERIOD_NS / SRC_PERIOD_NS))`. For example, 10 and 30 give 3, and equal periods give 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| raw_i | input | 1 | Unsynchronized contact level |
| tick_i | input | 1 | Sample strobe, one cycle wide |
| level_o | output | 1 | Debounced level |
| rise_o | output | 1 | Rising-edge pulse, `PULSE_W` cycles |
| fall_o | output | 1 | Falling-edge pulse, `PULSE_W` cycles |

## Verification
Two configurations run side by side: a 2-stage synchronizer with a window filter and single-cycle pulses, and a 3-stage synchronizer with a count filter and 3-cycle pulses. Every 8-bit raw pattern is played with varying hold lengths and sample spacings. Short bursts tell the two filters apart, because the counter keeps its partial progress across a bounce while the window restarts. Long steady runs produce the edges and the pulse widths. Directed steps then measure the end-to-end latency, the frozen behaviour with the strobe held low, and the quiet outputs after reset.

// File: rtl/deb_pkg.sv
package deb_pkg;
  typedef enum logic {
    FLT_SHIFT = 1'b0,
    FLT_COUNT = 1'b1
  } flt_mode_e;
endpackage

// File: rtl/deb_sync.sv
module deb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/deb_filter.sv
module deb_filter
  import deb_pkg::*;
#(
  parameter int        RUN_LEN = 12,
  parameter flt_mode_e MODE    = FLT_SHIFT
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic smp_i,
  input  logic tick_i,
  output logic level_o
);
  logic level_q;

  generate
    if (MODE == FLT_SHIFT) begin : g_window
      logic [RUN_LEN-1:0] win_q;
      logic [RUN_LEN-1:0] win_nxt;
      assign win_nxt = {win_q[RUN_LEN-2:0], smp_i};

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          win_q   <= '0;
          level_q <= 1'b0;
        end else if (tick_i) begin
          win_q <= win_nxt;
          if (&win_nxt)       level_q <= 1'b1;
          else if (~|win_nxt) level_q <= 1'b0;
        end
      end
    end else begin : g_count
      localparam int CW = $clog2(RUN_LEN + 1);
      localparam logic [CW-1:0] TOP = CW'(RUN_LEN);
      logic [CW-1:0] cnt_q;
      logic [CW-1:0] cnt_nxt;

      always_comb begin
        cnt_nxt = cnt_q;
        if (smp_i) begin
          if (cnt_q != TOP) cnt_nxt = cnt_q + 1'b1;
        end else begin
          if (cnt_q != '0)  cnt_nxt = cnt_q - 1'b1;
        end
      end

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          cnt_q   <= '0;
          level_q <= 1'b0;
        end else if (tick_i) begin
          cnt_q <= cnt_nxt;
          if (cnt_nxt == TOP)     level_q <= 1'b1;
          else if (cnt_nxt == '0) level_q <= 1'b0;
        end
      end
    end
  endgenerate

  assign level_o = level_q;
endmodule

// File: rtl/deb_edge.sv
module deb_edge #(
  parameter int PULSE_W = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic level_i,
  output logic rise_o,
  output logic fall_o
);
  localparam int PCW = $clog2(PULSE_W + 1);
  localparam logic [PCW-1:0] LOAD = PCW'(PULSE_W);

  logic       prev_q;
  logic [1:0] det;
  logic [1:0] act;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= level_i;
  end

  assign det[0] =  level_i & ~prev_q;
  assign det[1] = ~level_i &  prev_q;

  generate
    for (genvar c = 0; c < 2; c++) begin : g_chan
      logic [PCW-1:0] left_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)          left_q <= '0;
        else if (det[c])      left_q <= LOAD;
        else if (left_q != 0) left_q <= left_q - 1'b1;
      end
      assign act[c] = (left_q != '0);
    end
  endgenerate

  assign rise_o = act[0];
  assign fall_o = act[1];
endmodule

// File: rtl/contact_debounce.sv
module contact_debounce
  import deb_pkg::*;
#(
  parameter int        SYNC_STAGES   = 2,
  parameter int        RUN_LEN       = 12,
  parameter flt_mode_e FILTER_MODE   = FLT_SHIFT,
  parameter int        SRC_PERIOD_NS = 10,
  parameter int        DST_PERIOD_NS = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  input  logic tick_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int RATIO   = (DST_PERIOD_NS + SRC_PERIOD_NS - 1) / SRC_PERIOD_NS;
  localparam int PULSE_W = (RATIO < 1) ? 1 : RATIO;

  logic smp;
  logic level;

  deb_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw_i),
    .q_o   (smp)
  );

  deb_filter #(.RUN_LEN(RUN_LEN), .MODE(FILTER_MODE)) u_filt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .smp_i  (smp),
    .tick_i (tick_i),
    .level_o(level)
  );

  deb_edge #(.PULSE_W(PULSE_W)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .level_i(level),
    .rise_o (rise_o),
    .fall_o (fall_o)
  );

  assign level_o = level;
endmodule

// File: rtl/contact_debounce_chk.sv
module contact_debounce_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic tick_i,
  input logic level_o,
  input logic rise_o,
  input logic fall_o
);
  AST_FROZEN_NO_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(level_o)); // R2
  AST_RISE_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(level_o) |=> rise_o); // R6
  AST_FALL_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(level_o) |=> fall_o); // R7
  AST_RISE_HIGH_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rise_o) |-> level_o); // R6
  AST_FALL_LOW_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fall_o) |-> !level_o); // R7
endmodule

bind contact_debounce contact_debounce_chk u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .tick_i (tick_i),
  .level_o(level_o),
  .rise_o (rise_o),
  .fall_o (fall_o)
);

// File: tb/sim_contact_debounce.sv
`timescale 1ns/1ps
module sim_ref_deb #(
  parameter int S   = 2,
  parameter int N   = 4,
  parameter bit CNT = 0,
  parameter int PW  = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  input  logic tick,
  output logic lvl,
  output logic rise,
  output logic fall
);
  logic [S-1:0] dly;
  int run, up, rleft, fleft;
  logic last, prev;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dly <= '0; run <= N; last <= 1'b0; up <= 0; lvl <= 1'b0;
      prev <= 1'b0; rleft <= 0; fleft <= 0;
    end else begin
      dly <= {dly[S-2:0], raw};
      if (tick) begin
        if (!CNT) begin
          int r;
          r = (dly[S-1] == last) ? run + 1 : 1;
          run  <= r;
          last <= dly[S-1];
          if (r >= N) lvl <= dly[S-1];
        end else begin
          int u;
          u = dly[S-1] ? ((up < N) ? up + 1 : N) : ((up > 0) ? up - 1 : 0);
          up <= u;
          if (u == N) lvl <= 1'b1;
          else if (u == 0) lvl <= 1'b0;
        end
      end
      prev  <= lvl;
      rleft <= (lvl && !prev) ? PW : ((rleft > 0) ? rleft - 1 : 0);
      fleft <= (!lvl && prev) ? PW : ((fleft > 0) ? fleft - 1 : 0);
    end
  end
  assign rise = rleft > 0;
  assign fall = fleft > 0;
endmodule

module sim_contact_debounce;
  import deb_pkg::*;
  localparam int N = 4;
  localparam int PW1 = (30 + 10 - 1) / 10; // ceil(30/10) per R8

  logic clk = 1'b0, rst_n = 1'b0, raw = 1'b0, tick = 1'b0;
  logic l0, r0, f0, l1, r1, f1;
  logic el0, er0, ef0, el1, er1, ef1;
  int errs = 0, checks = 0;
  bit cmp_en = 0, done = 0;

  always #5 clk = ~clk;

  contact_debounce #(.SYNC_STAGES(2), .RUN_LEN(N), .FILTER_MODE(FLT_SHIFT),
    .SRC_PERIOD_NS(10), .DST_PERIOD_NS(10)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .raw_i(raw), .tick_i(tick),
    .level_o(l0), .rise_o(r0), .fall_o(f0));

  contact_debounce #(.SYNC_STAGES(3), .RUN_LEN(N), .FILTER_MODE(FLT_COUNT),
    .SRC_PERIOD_NS(10), .DST_PERIOD_NS(30)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .raw_i(raw), .tick_i(tick),
    .level_o(l1), .rise_o(r1), .fall_o(f1));

  sim_ref_deb #(.S(2), .N(N), .CNT(0), .PW(1)) m0 (
    .clk(clk), .rst_n(rst_n), .raw(raw), .tick(tick), .lvl(el0), .rise(er0), .fall(ef0));
  sim_ref_deb #(.S(3), .N(N), .CNT(1), .PW(PW1)) m1 (
    .clk(clk), .rst_n(rst_n), .raw(raw), .tick(tick), .lvl(el1), .rise(er1), .fall(ef1));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (cmp_en) begin
    chk("R3 window level", l0, el0);
    chk("R4 count level", l1, el1);
    chk("R6 rise u0", r0, er0);
    chk("R6 rise u1", r1, er1);
    chk("R7 fall u0", f0, ef0);
    chk("R7 fall u1", f1, ef1);
  end

  task automatic step(input logic rv, input logic tv);
    raw = rv; tick = tv;
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    int lat0, lat1, w0, w1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R5: quiet after reset
    chk("R5 level u0", l0, 0); chk("R5 level u1", l1, 0);
    chk("R5 rise u0", r0, 0); chk("R5 fall u1", f1, 0);
    cmp_en = 1;
    repeat (8) step(1'b0, 1'b1);
    chk("R5 no pulse u0", r0 | f0, 0);
    chk("R5 no pulse u1", r1 | f1, 0);
    // R1: latency from first edge seeing raw high
    lat0 = 0; lat1 = 0; raw = 1'b1; tick = 1'b1;
    for (int k = 1; k <= 20; k++) begin
      @(negedge clk);
      if (l0 && lat0 == 0) lat0 = k;
      if (l1 && lat1 == 0) lat1 = k;
    end
    chk("R1 latency 2-stage", lat0, 2 + N);
    chk("R1 latency 3-stage", lat1, 3 + N);
    // R8: fall pulse widths
    w0 = 0; w1 = 0; raw = 1'b0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      w0 += f0; w1 += f1;
    end
    chk("R8 width u0", w0, 1);
    chk("R8 width u1", w1, PW1);
    // R2: strobe low freezes level
    repeat (12) step(1'b1, 1'b1);
    for (int k = 0; k < 15; k++) step(1'b0, 1'b0);
    chk("R2 frozen u0", l0, 1);
    chk("R2 frozen u1", l1, 1);
    repeat (12) step(1'b0, 1'b1);
    chk("R2 resumes u0", l0, 0);
    // sweep: all 8-bit patterns, varying hold and strobe spacing (R3 R4 R6 R7)
    for (int p = 0; p < 256; p++) begin
      int hold, div, cyc;
      hold = 1 + (p % 3); div = 1 + ((p / 3) % 2); cyc = 0;
      for (int b = 0; b < 8; b++)
        for (int h = 0; h < hold; h++) begin
          step(p[b], (cyc % div) == 0);
          cyc++;
        end
      if (p % 16 == 15) begin
        repeat (14) step(p[0], 1'b1);
      end
    end
    repeat (10) step(1'b0, 1'b1);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule